// File: doc/BRIEF.md
# Receive Character Queue with Holding Stage

This block buffers received characters for one serial receive channel. Each stored character carries an 8-bit data byte and three status bits: break, framing error and parity error. The queue is sixteen characters deep. A receiver pushes characters into it, and a host read strobe pops them in arrival order. The oldest character is always visible on the head outputs, so a read takes the value shown in the cycle of the strobe.

One holding stage sits in front of the queue and stands in for the receive shift register. When a character arrives and all sixteen positions are in use, the character waits in the holding stage. The next read moves it into the queue in the same cycle that frees a position, so the full flag stays up until a second read.

If another character arrives while one is already waiting, the waiting character and its status are replaced, and a sticky overrun flag is raised. Only an error-clear pulse lowers that flag. A receiver-clear pulse empties both the queue and the holding stage.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset, `rx_rdy_o`, `rx_full_o` and `overrun_o` are all 0.
- R2: Characters are read in the order they were pushed. The head outputs show the oldest character's data, break, framing and parity bits, and `pop_i` removes that character at the clock edge.
- R3: `rx_rdy_o` is 1 exactly when the queue holds one or more characters.
- R4: `rx_full_o` becomes 1 in the cycle after the push that stores the sixteenth character.
- R5: When the queue is full and nothing waits in the holding stage, a read clears `rx_full_o` in the next cycle.
- R6: A push while the queue is full and no read is made places the character in the holding stage. The next read moves it into the queue, so `rx_full_o` stays 1, and a second read clears it.
- R7: A push while a character is waiting, with no read in that cycle, replaces the waiting character and its three status bits, and sets `overrun_o` in the next cycle.
- R8: `overrun_o` is sticky. `rst_rx_i` does not clear it; only `rst_err_i` does. If an overrun event and `rst_err_i` occur in the same cycle, the flag is set.
- R9: `rst_rx_i` empties the queue and the holding stage and clears `rx_rdy_o` and `rx_full_o`. A push made in that same cycle is dropped.
- R10: A push and a read in the same cycle are both honoured, and the number of stored characters is unchanged.
- R11: A read while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Received character is valid this cycle |
| push_data_i | input | 8 | Received data byte |
| push_brk_i | input | 1 | Received character is a break |
| push_fe_i | input | 1 | Received character has a framing error |
| push_pe_i | input | 1 | Received character has a parity error |
| pop_i | input | 1 | Host read strobe |
| rst_err_i | input | 1 | Clear the overrun flag |
| rst_rx_i | input | 1 | Empty queue and holding stage |
| pop_data_o | output | 8 | Head character data |
| pop_brk_o | output | 1 | Head character break bit |
| pop_fe_o | output | 1 | Head character framing bit |
| pop_pe_o | output | 1 | Head character parity bit |
| rx_rdy_o | output | 1 | At least one character stored |
| rx_full_o | output | 1 | All sixteen positions in use |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The queue is first driven with a short mix of single pushes, single reads, a combined push and read, and a read while empty. Each case shows a different effect on order and occupancy.

Two full fills then reach the boundary cases. The first fill tells the full-with-nothing-waiting case apart from the full-with-a-character-waiting case: only the second needs two reads to drop the full flag. The same fill replaces a waiting character and then drains the queue. This proves the replaced character's byte and status bits are gone and that the newer one arrives last.

The second fill raises overrun again before a receiver clear. This separates what the receiver clear empties from the overrun flag, which it must leave alone.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  parameter int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [CHAR_W-1:0] data;
  } rx_char_t;

  // occupancy after one cycle, given a write and a read
  function automatic int unsigned next_level(int unsigned lvl, logic wr, logic rd);
    return lvl + (wr ? 1 : 0) - (rd ? 1 : 0);
  endfunction

  // ring pointer advance that also handles depths that are not powers of two
  function automatic int unsigned ring_next(int unsigned ptr, int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  rx_char_t      wr_char,
  input  logic          rd_en,
  output rx_char_t      head,
  output logic [CW-1:0] level
);
  rx_char_t      mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_en) wr_ptr <= PW'(ring_next(int'(wr_ptr), DEPTH));
      if (rd_en) rd_ptr <= PW'(ring_next(int'(rd_ptr), DEPTH));
      level <= CW'(next_level(int'(level), wr_en, rd_en));
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wr_ptr] <= wr_char;
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/rxq_hold.sv
module rxq_hold
  import rxq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     load,
  input  rx_char_t in_char,
  input  logic     take,
  output logic     valid,
  output rx_char_t out_char
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      out_char <= '0;
    end else if (clr) begin
      valid <= 1'b0;
    end else if (load) begin
      valid    <= 1'b1;
      out_char <= in_char;
    end else if (take) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          clr,
  input  logic          err_clr,
  input  logic          hold_v,
  input  logic [CW-1:0] level,
  output logic          rd_en,
  output logic          wr_en,
  output logic          wr_from_hold,
  output logic          hold_load,
  output logic          hold_take,
  output logic          ovr_event,
  output logic          is_full,
  output logic          is_empty,
  output logic          overrun
);
  assign is_full  = (level == CW'(DEPTH));
  assign is_empty = (level == '0);

  always_comb begin
    rd_en        = pop && !is_empty && !clr;
    wr_en        = 1'b0;
    wr_from_hold = 1'b0;
    hold_load    = 1'b0;
    hold_take    = 1'b0;
    ovr_event    = 1'b0;
    if (!clr) begin
      if (hold_v) begin
        wr_en        = rd_en;
        wr_from_hold = 1'b1;
        hold_take    = rd_en;
        hold_load    = push;
        ovr_event    = push && !rd_en;
      end else begin
        wr_en     = push && (!is_full || rd_en);
        hold_load = push && is_full && !rd_en;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overrun <= 1'b0;
    else if (ovr_event) overrun <= 1'b1;
    else if (err_clr)   overrun <= 1'b0;
  end
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [CHAR_W-1:0] push_data_i,
  input  logic              push_brk_i,
  input  logic              push_fe_i,
  input  logic              push_pe_i,
  input  logic              pop_i,
  input  logic              rst_err_i,
  input  logic              rst_rx_i,
  output logic [CHAR_W-1:0] pop_data_o,
  output logic              pop_brk_o,
  output logic              pop_fe_o,
  output logic              pop_pe_o,
  output logic              rx_rdy_o,
  output logic              rx_full_o,
  output logic              overrun_o
);
  rx_char_t      in_char, hold_char, wr_char, head;
  logic [CW-1:0] level;
  logic          rd_en, wr_en, wr_from_hold, hold_load, hold_take;
  logic          ovr_event, is_full, is_empty, hold_v;

  assign in_char = '{brk: push_brk_i, fe: push_fe_i, pe: push_pe_i, data: push_data_i};
  assign wr_char = wr_from_hold ? hold_char : in_char;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push(push_i), .pop(pop_i), .clr(rst_rx_i),
    .err_clr(rst_err_i), .hold_v(hold_v), .level(level), .rd_en(rd_en),
    .wr_en(wr_en), .wr_from_hold(wr_from_hold), .hold_load(hold_load),
    .hold_take(hold_take), .ovr_event(ovr_event), .is_full(is_full),
    .is_empty(is_empty), .overrun(overrun_o)
  );

  rxq_hold u_hold (
    .clk(clk), .rst_n(rst_n), .clr(rst_rx_i), .load(hold_load),
    .in_char(in_char), .take(hold_take), .valid(hold_v), .out_char(hold_char)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(rst_rx_i), .wr_en(wr_en),
    .wr_char(wr_char), .rd_en(rd_en), .head(head), .level(level)
  );

  assign pop_data_o = head.data;
  assign pop_brk_o  = head.brk;
  assign pop_fe_o   = head.fe;
  assign pop_pe_o   = head.pe;
  assign rx_rdy_o   = !is_empty;
  assign rx_full_o  = is_full;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
  input logic clk,
  input logic rst_n,
  input logic push,
  input logic pop,
  input logic rst_err,
  input logic rst_rx,
  input logic rx_rdy,
  input logic rx_full,
  input logic overrun,
  input logic hold_v
);
  p_reset_clear_r1: assert property (@(posedge clk) $rose(rst_n) |-> !overrun && !rx_rdy);

  p_full_has_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rx_rdy);

  p_hold_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |-> rx_full);

  p_hold_pop_keeps_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v && pop && !rst_rx |=> rx_full);

  p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(push && hold_v && !pop && !rst_rx));

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !rst_err |=> overrun);

  p_rx_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_rx |=> !rx_rdy && !rx_full && !hold_v);

  p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rdy && pop && !push |=> !rx_rdy);
endmodule

bind rx_char_fifo rxq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .push(push_i), .pop(pop_i), .rst_err(rst_err_i),
  .rst_rx(rst_rx_i), .rx_rdy(rx_rdy_o), .rx_full(rx_full_o),
  .overrun(overrun_o), .hold_v(hold_v)
);

// File: tb/tb_rx_char_fifo.sv
module tb_rx_char_fifo;
  logic clk = 1'b0, rst_n = 1'b0;
  logic push = 0, pop = 0, rst_err = 0, rst_rx = 0;
  logic [7:0] pd = 0;
  logic pb = 0, pf = 0, pp = 0;
  logic [7:0] qd;
  logic qb, qf, qp, rdy, full, ovr;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rx_char_fifo dut (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(pd), .push_brk_i(pb),
    .push_fe_i(pf), .push_pe_i(pp), .pop_i(pop), .rst_err_i(rst_err),
    .rst_rx_i(rst_rx), .pop_data_o(qd), .pop_brk_o(qb), .pop_fe_o(qf),
    .pop_pe_o(qp), .rx_rdy_o(rdy), .rx_full_o(full), .overrun_o(ovr)
  );

  // push, pop, status{brk,fe,pe}, data, expected rdy, full, head{status,data}
  typedef struct packed {
    logic       psh;
    logic       pp;
    logic [2:0] st;
    logic [7:0] d;
    logic       erdy;
    logic       efull;
    logic [10:0] ehead;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 3'b000, 8'h11, 1'b1, 1'b0, 11'h011},
    '{1'b1, 1'b0, 3'b101, 8'h22, 1'b1, 1'b0, 11'h011},
    '{1'b1, 1'b1, 3'b000, 8'h33, 1'b1, 1'b0, 11'h522},
    '{1'b0, 1'b1, 3'b000, 8'h00, 1'b1, 1'b0, 11'h033},
    '{1'b0, 1'b1, 3'b000, 8'h00, 1'b0, 1'b0, 11'h000},
    '{1'b0, 1'b1, 3'b000, 8'h00, 1'b0, 1'b0, 11'h000},
    '{1'b1, 1'b0, 3'b010, 8'h44, 1'b1, 1'b0, 11'h244},
    '{1'b0, 1'b1, 3'b000, 8'h00, 1'b0, 1'b0, 11'h000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at the falling edge, sample one time unit after the rising edge
  task automatic cyc(input logic ps, input logic po, input logic [2:0] st,
                     input logic [7:0] d, input logic ce = 0, input logic cr = 0);
    @(negedge clk);
    push = ps; pop = po; {pb, pf, pp} = st; pd = d; rst_err = ce; rst_rx = cr;
    @(posedge clk);
    #1;
    push = 0; pop = 0; rst_err = 0; rst_rx = 0;
  endtask

  task automatic fill(input logic [7:0] base);
    for (int i = 0; i < 16; i++) begin
      cyc(1, 0, 3'b000, base + 8'(i));
      if (i == 14) chk("R4 not full at 15", full, 0);
    end
    chk("R4 full at 16", full, 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20;
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 rdy", rdy, 0);
    chk("R1 full", full, 0);
    chk("R1 ovr", ovr, 0);

    // table walk: order R2, level R3, push+pop R10, empty pop R11
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].psh, VEC[i].pp, VEC[i].st, VEC[i].d);
      chk("R3 rdy", rdy, VEC[i].erdy);
      chk("R10 full", full, VEC[i].efull);
      if (VEC[i].erdy) chk("R2 head", {qb, qf, qp, qd}, VEC[i].ehead);
    end

    // fill 0x00..0x0F
    fill(8'h00);
    cyc(0, 1, 3'b000, 0);
    chk("R5 full cleared", full, 0);
    chk("R2 head after pop", qd, 8'h01);
    cyc(1, 0, 3'b000, 8'h10);
    chk("R4 refull", full, 1);
    cyc(1, 0, 3'b111, 8'hA0);     // waits in holding stage
    chk("R6 no ovr yet", ovr, 0);
    cyc(1, 0, 3'b000, 8'hB0);     // replaces waiting character
    chk("R7 ovr set", ovr, 1);
    cyc(0, 1, 3'b000, 0);
    chk("R6 full after first read", full, 1);
    cyc(0, 1, 3'b000, 0);
    chk("R6 full cleared second read", full, 0);
    for (int v = 3; v <= 16; v++) begin
      chk("R2 drain order", qd, 8'(v));
      cyc(0, 1, 3'b000, 0);
    end
    chk("R7 replaced char data+status", {qb, qf, qp, qd}, 11'h0B0);
    cyc(0, 1, 3'b000, 0);
    chk("R3 empty after drain", rdy, 0);
    chk("R8 ovr sticky", ovr, 1);
    cyc(0, 0, 3'b000, 0, 1);
    chk("R8 ovr cleared", ovr, 0);

    // second fill, overrun again, then receiver clear
    fill(8'h40);
    cyc(1, 0, 3'b000, 8'hC0);
    cyc(1, 0, 3'b000, 8'hC1);
    chk("R7 ovr set again", ovr, 1);
    cyc(1, 0, 3'b000, 8'hC2, 0, 1);
    chk("R9 rdy cleared", rdy, 0);
    chk("R9 full cleared", full, 0);
    chk("R8 ovr kept by rx clear", ovr, 1);
    cyc(1, 0, 3'b011, 8'h5A);
    chk("R9 fresh head", {qb, qf, qp, qd}, 11'h35A);
    cyc(0, 1, 3'b000, 0);
    chk("R9 hold emptied", rdy, 0);
    cyc(0, 0, 3'b000, 0, 1);
    chk("R8 ovr cleared again", ovr, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule